// File: doc/BRIEF.md
# Timer Tick Prescaler and Divider

This block turns one base clock into a set of single-cycle tick enables, one per timer channel, for the channel counters that sit downstream of it. Two 8-bit prescalers divide the base clock. The low group of channels (0 and 1) shares one prescaler, and the high group (2 to 4) shares the other. Each prescaler divides by its programmed value plus one.

Every channel has a 4-bit selector with two kinds of code. A division code divides its group's prescaler output by a power of two. The other kind of code replaces the division with a tick taken from an external input. Each group has its own external input. The input is brought into the clock domain through two flops, and each rising edge becomes one tick.

Configuration is written as two 32-bit words through a single-cycle write port. A new prescaler value is not applied at once. It is loaded at that prescaler's next terminal count, so the tick interval in progress is never cut short.

Top module: `tick_clock_gen`

## Requirements
- R1: While `rst_n` is low every `tick_en` bit is 0. Reset clears both configuration words, so from the first cycle after reset every channel ticks on every cycle.
- R2: A write with `cfg_wr_addr` = 0 loads the prescaler word. Prescaler A is bits 7:0 and prescaler B is bits 15:8. A prescaler value P gives one prescaler tick every P+1 cycles.
- R3: Channels 0 and 1 are timed from prescaler A and external input `ext_tick_a`. Channels 2, 3 and 4 are timed from prescaler B and `ext_tick_b`.
- R4: A write with `cfg_wr_addr` = 1 loads the selector word. The selector for channel c is bits 4c+3:4c. With DIV_BASE = 0, a division code n gives one tick every (P+1)·2^n cycles, each tick lasting one cycle.
- R5: A code whose bit is set in EXT_MASK picks the external input. By default these are codes 5, 6 and 7. Any other code, including 4, picks a division.
- R6: On a channel set to external, a rising edge on its group's input gives exactly one tick, three clock edges after the input is sampled high. A held high level gives no further ticks, and the other group's channels do not respond.
- R7: A prescaler value written during a count takes effect at that prescaler's next terminal count. The interval in progress keeps its old length, and the next interval uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr_en | input | 1 | Single-cycle configuration write strobe |
| cfg_wr_addr | input | 1 | 0 = prescaler word, 1 = selector word |
| cfg_wr_data | input | 32 | Configuration word to write |
| ext_tick_a | input | 1 | External tick source for channels 0–1 (asynchronous) |
| ext_tick_b | input | 1 | External tick source for channels 2–4 (asynchronous) |
| tick_en | output | 5 | One single-cycle tick enable per channel |

## Verification
Division is checked with two sets of prescaler and selector values. In the first set, prescaler A is slow and prescaler B is undivided. In the second set this is reversed. The measured tick spacing on each channel shows whether its prescaler group, its selector field position and its exponent are right. Code 4 is included to show that it divides, because it lies next to the external codes. Prescaler timing is checked by changing the value in the middle of a count: the interval in progress must keep its old length and the next one must take the new length. The external path is driven on one group at a time and sampled cycle by cycle, which checks the latency, that each edge gives exactly one pulse, and that the groups stay separate.

// File: rtl/tick_clock_gen_pkg.sv
// Shared definitions for the tick prescaler/divider.
// Assumes: a configuration address of one bit selects between two words.
package tick_clock_gen_pkg;

    // Which configuration word a write targets.
    typedef enum logic {
        CFG_PRESCALE = 1'b0,
        CFG_SELECT   = 1'b1
    } cfg_word_e;

    // Map a channel index to its prescaler / external-input group.
    function automatic int group_of(input int ch, input int split);
        return (ch < split) ? 0 : 1;
    endfunction

endpackage

// File: rtl/tcg_prescaler.sv
// Down-counting prescaler: emits a tick every (reload+1) cycles.
// Assumes: reload_i is sampled only at terminal count, so a changed value
// never cuts short the interval already running.
module tcg_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] reload_i,
    output logic         tick_o
);

    logic [W-1:0] cnt_q;

    assign tick_o = (cnt_q == '0);

    // Count down; on terminal count reload the currently programmed value.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= reload_i;
        else             cnt_q <= cnt_q - 1'b1;
    end

    // R7: the value used for a new interval is the one present at terminal count
    p_reload_at_terminal_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (cnt_q == $past(reload_i)));

    // R2: between terminal counts the count only moves downward
    p_count_falls_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        !tick_o |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/tcg_ext_sync.sv
// Brings an asynchronous external tick into the clock domain through two
// flops and turns each rising edge into a one-cycle pulse.
// Assumes: the external input stays high or low for at least one cycle.
module tcg_ext_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic pulse_o
);

    logic [2:0] sh_q;

    // Two synchroniser stages plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[1:0], async_i};
    end

    assign pulse_o = sh_q[1] & ~sh_q[2];

    // R6: an edge pulse never lasts longer than one cycle
    p_pulse_single_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

endmodule

// File: rtl/tcg_chan_div.sv
// Per-channel stage: divides the group prescaler tick by 2^(code+DIV_BASE),
// or passes the group's external pulse when the code is marked in EXT_MASK.
// Assumes: pre_tick_i and ext_pulse_i are single-cycle enables in clk domain.
module tcg_chan_div #(
    parameter int                      SEL_W    = 4,
    parameter int                      DIV_BASE = 0,
    parameter logic [(2**SEL_W)-1:0]   EXT_MASK = 'h00E0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             pre_tick_i,
    input  logic             ext_pulse_i,
    output logic             tick_o
);

    localparam int MAX_EXP = (2**SEL_W) - 1 + DIV_BASE;
    localparam int CW      = (MAX_EXP > 0) ? MAX_EXP : 1;

    logic [CW-1:0]  div_q;
    logic [CW-1:0]  low_mask;
    logic [SEL_W:0] exp_w;
    logic           ext_sel;
    logic           div_hit;

    assign ext_sel = EXT_MASK[sel_i];
    assign exp_w   = {1'b0, sel_i} + (SEL_W+1)'(DIV_BASE);

    // Build the mask of the low exp_w bits of the divide counter.
    always_comb begin
        for (int i = 0; i < CW; i++) begin
            low_mask[i] = (i < int'(exp_w));
        end
    end

    assign div_hit = pre_tick_i && ((div_q & low_mask) == low_mask);

    // Free-running divide counter advanced by each prescaler tick.
    always_ff @(posedge clk) begin
        if (!rst_n)          div_q <= '0;
        else if (pre_tick_i) div_q <= div_q + 1'b1;
    end

    // Register the selected tick source onto the channel output.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_o <= 1'b0;
        else        tick_o <= ext_sel ? ext_pulse_i : div_hit;
    end

    // R4: a divided tick always follows a prescaler tick
    p_div_needs_prescale_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !$past(ext_sel)) |-> $past(pre_tick_i));

    // R5: an externally selected tick always follows an external pulse
    p_ext_needs_pulse_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && $past(ext_sel)) |-> $past(ext_pulse_i));

endmodule

// File: rtl/tick_clock_gen.sv
// Top: configuration words, two group prescalers, two external-tick
// synchronisers and one divider stage per channel.
// Assumes: NUM_CH*SEL_W and 2*PRE_W fit in one CFG_W-bit word.
module tick_clock_gen
    import tick_clock_gen_pkg::*;
#(
    parameter int                    NUM_CH   = 5,
    parameter int                    SPLIT_CH = 2,
    parameter int                    PRE_W    = 8,
    parameter int                    SEL_W    = 4,
    parameter int                    CFG_W    = 32,
    parameter int                    DIV_BASE = 0,
    parameter logic [(2**SEL_W)-1:0] EXT_MASK = 'h00E0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_wr_addr,
    input  logic [CFG_W-1:0]  cfg_wr_data,
    input  logic              ext_tick_a,
    input  logic              ext_tick_b,
    output logic [NUM_CH-1:0] tick_en
);

    localparam int NUM_GRP = 2;
    localparam int PRE_BITS = NUM_GRP * PRE_W;
    localparam int SEL_BITS = NUM_CH * SEL_W;

    logic [PRE_BITS-1:0] presc_q;
    logic [SEL_BITS-1:0] sel_q;
    logic [NUM_GRP-1:0]  grp_tick;
    logic [NUM_GRP-1:0]  grp_pulse;
    logic [NUM_GRP-1:0]  ext_raw;
    logic                unused_cfg_hi;

    assign ext_raw       = {ext_tick_b, ext_tick_a};
    assign unused_cfg_hi = ^cfg_wr_data[CFG_W-1:PRE_BITS];

    // Load the addressed configuration word on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= '0;
            sel_q   <= '0;
        end else if (cfg_wr_en) begin
            if (cfg_word_e'(cfg_wr_addr) == CFG_PRESCALE) presc_q <= cfg_wr_data[PRE_BITS-1:0];
            else                                          sel_q   <= cfg_wr_data[SEL_BITS-1:0];
        end
    end

    // One prescaler and one external synchroniser per channel group.
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        tcg_prescaler #(.W(PRE_W)) i_presc (
            .clk      (clk),
            .rst_n    (rst_n),
            .reload_i (presc_q[g*PRE_W +: PRE_W]),
            .tick_o   (grp_tick[g])
        );
        tcg_ext_sync i_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (ext_raw[g]),
            .pulse_o (grp_pulse[g])
        );
    end

    // One divider stage per channel, wired to its group's sources.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int GRP = group_of(c, SPLIT_CH);
        tcg_chan_div #(
            .SEL_W    (SEL_W),
            .DIV_BASE (DIV_BASE),
            .EXT_MASK (EXT_MASK)
        ) i_div (
            .clk         (clk),
            .rst_n       (rst_n),
            .sel_i       (sel_q[c*SEL_W +: SEL_W]),
            .pre_tick_i  (grp_tick[GRP]),
            .ext_pulse_i (grp_pulse[GRP]),
            .tick_o      (tick_en[c])
        );
    end

    // R1: outputs are quiet in the cycle after a reset edge
    p_quiet_after_reset_r1 : assert property (@(posedge clk)
        !rst_n |=> (tick_en == '0));

endmodule

// File: tb/test_tick_clock_gen.sv
// Directed bench for tick_clock_gen: one task per scenario.
module test_tick_clock_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_wr_addr = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic        ext_tick_a = 1'b0;
    logic        ext_tick_b = 1'b0;
    logic [4:0]  tick_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    tick_clock_gen i_tick_clock_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_addr (cfg_wr_addr),
        .cfg_wr_data (cfg_wr_data),
        .ext_tick_a  (ext_tick_a),
        .ext_tick_b  (ext_tick_b),
        .tick_en     (tick_en)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic addr, input logic [31:0] data);
        cfg_wr_en   = 1'b1;
        cfg_wr_addr = addr;
        cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    // Count negedges until the channel's tick is seen (bounded).
    task automatic wait_tick(input int ch, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (tick_en[ch] !== 1'b1 && n < 3000);
    endtask

    // Skip settling intervals, then measure one full tick spacing.
    task automatic measure(input int ch, input int exp, input string req);
        int n;
        for (int k = 0; k < 3; k++) wait_tick(ch, n);
        wait_tick(ch, n);
        check(req, n, exp);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R1 during reset", int'(tick_en), 0);
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R1 every cycle after reset", int'(tick_en), 5'h1F);
        end
    endtask

    // Pattern A: prescaler A = 2, prescaler B = 0; codes 3,0,2,1,4.
    task automatic t_div_a;
        cfg_write(1'b0, 32'h0000_0002);
        cfg_write(1'b1, 32'h0004_1203);
        measure(0, 24, "R4 ch0 code3 presA=2");
        measure(1, 3,  "R2 ch1 code0 presA=2");
        measure(2, 4,  "R3 ch2 code2 presB=0");
        measure(3, 2,  "R3 ch3 code1 presB=0");
        measure(4, 16, "R5 ch4 code4 divides");
    endtask

    // Pattern B: prescaler A = 0, prescaler B = 4; codes 2,1,0,3,1.
    task automatic t_div_b;
        cfg_write(1'b0, 32'h0000_0400);
        cfg_write(1'b1, 32'h0001_3012);
        measure(0, 4,  "R3 ch0 code2 presA=0");
        measure(1, 2,  "R4 ch1 code1 presA=0");
        measure(2, 5,  "R2 ch2 code0 presB=4");
        measure(3, 40, "R4 ch3 code3 presB=4");
        measure(4, 10, "R3 ch4 code1 presB=4");
    endtask

    // R7: a prescaler rewrite mid-count keeps the running interval.
    task automatic t_midcount;
        int n;
        cfg_write(1'b1, 32'h0000_0000);
        cfg_write(1'b0, 32'h0000_0009);
        measure(0, 10, "R7 steady old period");
        @(negedge clk);
        @(negedge clk);
        wait_tick(0, n);
        cfg_write(1'b0, 32'h0000_0001);
        wait_tick(0, n);
        check("R7 running interval kept", n + 1, 10);
        wait_tick(0, n);
        check("R7 next interval new value", n, 2);
    endtask

    // R6: external edges on one group at a time, sampled per cycle.
    task automatic t_external;
        cfg_write(1'b0, 32'h0000_0000);
        cfg_write(1'b1, 32'h0000_6050);   // ch1 code5, ch3 code6
        repeat (6) @(negedge clk);
        ext_tick_a = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            check($sformatf("R6 ch1 group A edge cycle %0d", k), int'(tick_en[1]), (k == 3) ? 1 : 0);
            check($sformatf("R6 ch3 ignores group A cycle %0d", k), int'(tick_en[3]), 0);
        end
        ext_tick_a = 1'b0;
        repeat (4) @(negedge clk);
        ext_tick_b = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            check($sformatf("R6 ch3 group B edge cycle %0d", k), int'(tick_en[3]), (k == 3) ? 1 : 0);
            check($sformatf("R6 ch1 ignores group B cycle %0d", k), int'(tick_en[1]), 0);
        end
        ext_tick_b = 1'b0;
    endtask

    initial begin
        t_reset();
        t_div_a();
        t_div_b();
        t_midcount();
        t_external();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule